// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through first-level data cache and the second-level cache. It accepts every store the processor issues. That includes stores that miss in the first-level cache, because that cache does not allocate on a write miss. Each store is held in a small line-sized slot until the downstream cache takes it.

A slot covers one 32-byte line. It keeps the line address, 32 bytes of data and a per-byte valid mask. A new store to a line that a slot already holds is folded into that slot rather than taking a new one. Slots leave in the order they were allocated, through a valid/ready handshake to the downstream cache.

When every slot is occupied and the incoming store has no slot to fold into, the buffer raises a stall. The stall stays up until a slot drains. A drain in the same cycle as the store frees a slot at once, so the store is taken without a stall cycle.

Top module: `cwb_top`

## Requirements
- R1: The buffer holds at most ENTRIES line slots (default 4). Each slot has a line address, 32 data bytes and a 32-bit mask, where mask bit i marks line byte i as written.
- R2: A store is accepted in any cycle with st_valid high and st_stall low. An accepted store writes byte b of its 4-byte word w to line byte 4*w+b for each b whose st_be bit is set, and sets the matching mask bits. st_waddr is a word address: bits [2:0] give w and the upper bits give the line address.
- R3: An accepted store whose line is already in a slot is merged into that slot. The enabled bytes are overwritten, the mask is ORed with the new enables, and no new slot is taken. Such a store never stalls, even when all slots are full.
- R4: st_stall is high exactly when all of these hold: st_valid is high, no slot can take a merge, every slot is occupied, and no drain happens in that cycle.
- R5: Slots are presented downstream in allocation order. Every accepted store's bytes reach the downstream port, and an empty buffer holds dn_valid low.
- R6: The oldest slot is presented with dn_valid high. It is removed only in a cycle where dn_ready is high, and otherwise stays presented with the same line address.
- R7: A store to the line of the oldest slot in a cycle where that slot is accepted downstream does not merge into it. The store takes a new slot, which drains later.
- R8: When the buffer is full and a slot drains in the same cycle that a non-merging store arrives, the store is accepted with no stall.
- R9: After a synchronous active-low reset the buffer is empty, with dn_valid and st_stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A store is offered this cycle |
| st_waddr | input | 30 | Word address of the store |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Byte enables of the store word |
| st_stall | output | 1 | Store cannot be taken this cycle |
| dn_valid | output | 1 | Oldest slot is offered downstream |
| dn_ready | input | 1 | Downstream takes the offered slot |
| dn_line | output | 27 | Line address of the offered slot |
| dn_data | output | 256 | Line data of the offered slot |
| dn_mask | output | 32 | Byte-written mask of the offered slot |

## Verification
A downstream drain can fall in the same cycle as an incoming store. In that cycle the two interact in two ways. A full buffer must accept the store, and a store to the draining line must open a fresh slot rather than merge into the slot being removed.

The bench provokes both cases directly. It then sweeps every line, word and byte-enable combination over a handful of lines while toggling dn_ready from a pseudo-random pattern, so drains collide with stores and merges throughout. A bench-side slot model decides, every cycle, the expected stall and the expected head slot, and it checks every downstream line, data and mask against that model.

// File: rtl/cwb_pkg.sv
// Package for the coalescing write buffer.
// Holds the fixed line geometry shared by every submodule and the bench.
// Assumes 4-byte store words and power-of-two line sizes.
package cwb_pkg;
    localparam int WORD_BYTES = 4;
    localparam int LINE_BYTES = 32;
    localparam int WADDR_W    = 30;
    localparam int WORDS      = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W     = $clog2(WORDS);
    localparam int LINE_W     = WADDR_W - WSEL_W;
    localparam int DATA_W     = LINE_BYTES * 8;
    localparam int WDATA_W    = WORD_BYTES * 8;

    typedef logic [LINE_W-1:0]     line_t;
    typedef logic [DATA_W-1:0]     ldata_t;
    typedef logic [LINE_BYTES-1:0] lmask_t;
    typedef logic [WDATA_W-1:0]    wdata_t;
    typedef logic [WORD_BYTES-1:0] wbe_t;
    typedef logic [WSEL_W-1:0]     wsel_t;
endpackage

// File: rtl/cwb_ring_ctrl.sv
// Ring pointer control for the slot array.
// Tracks the oldest slot (head), the next free slot (tail) and the occupancy.
// Assumes the caller never pushes into a full ring unless it pops in the same cycle.
module cwb_ring_ctrl #(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [CNT_W-1:0] occ,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ENTRIES);

    // Advance a pointer with wrap at the last slot.
    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Head pointer moves when the oldest slot leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)   head_idx <= '0;
        else if (pop) head_idx <= bump(head_idx);
    end

    // Tail pointer moves when a fresh slot is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    tail_idx <= '0;
        else if (push) tail_idx <= bump(tail_idx);
    end

    // Occupancy counts pushes minus pops.
    always_ff @(posedge clk) begin
        if (!rst_n)             occ <= '0;
        else if (push && !pop)  occ <= occ + 1'b1;
        else if (pop && !push)  occ <= occ - 1'b1;
    end

    // Status flags derived from the occupancy.
    always_comb begin
        full  = (occ == FULL_CNT);
        empty = (occ == '0);
    end
endmodule

// File: rtl/cwb_line_match.sv
// Line-address comparator across all slots.
// Reports whether a live slot holds the queried line and which one.
// One slot may be masked out of the search (the slot leaving this cycle).
// Assumes at most one live slot can match, so the lowest match index is taken.
module cwb_line_match #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 27,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             live,
    input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]              query,
    input  logic                           skip_en,
    input  logic [IDX_W-1:0]               skip_idx,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);
    logic [ENTRIES-1:0] eq;

    // Per-slot compare, with the skipped slot forced to miss.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        always_comb begin
            eq[i] = live[i] && (lines[i] == query)
                    && !(skip_en && (skip_idx == IDX_W'(i)));
        end
    end

    // Encode the matching slot index.
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cwb_byte_merge.sv
// Byte-lane merge of one store word into a line image.
// Overwrites enabled bytes of the selected word and ORs their mask bits.
// Assumes the caller supplies a cleared line image for a freshly taken slot.
module cwb_byte_merge
    import cwb_pkg::*;
(
    input  ldata_t base_data,
    input  lmask_t base_mask,
    input  wsel_t  word_sel,
    input  wdata_t wdata,
    input  wbe_t   be,
    output ldata_t out_data,
    output lmask_t out_mask
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
            localparam int LB = w * WORD_BYTES + b;
            logic sel;
            // Select this lane when the word matches and its enable is set.
            always_comb begin
                sel = (word_sel == WSEL_W'(w)) && be[b];
                out_data[LB*8 +: 8] = sel ? wdata[b*8 +: 8] : base_data[LB*8 +: 8];
                out_mask[LB]        = base_mask[LB] | sel;
            end
        end
    end
endmodule

// File: rtl/cwb_top.sv
// Coalescing write buffer between a write-through L1 data cache and L2.
// Takes every store, merges stores that hit a buffered line, drains slots
// oldest first over a valid/ready port, and stalls stores only when no slot
// is free, no merge is possible and nothing drains this cycle.
// Assumes the store source holds its request while st_stall is high.
module cwb_top
    import cwb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [WADDR_W-1:0]   st_waddr,
    input  logic [WDATA_W-1:0]   st_data,
    input  logic [WORD_BYTES-1:0] st_be,
    output logic                 st_stall,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [LINE_W-1:0]    dn_line,
    output logic [DATA_W-1:0]    dn_data,
    output logic [LINE_BYTES-1:0] dn_mask
);
    // Slot storage.
    logic [ENTRIES-1:0]             ent_live;
    logic [ENTRIES-1:0][LINE_W-1:0] ent_line;
    ldata_t                         ent_data [ENTRIES];
    lmask_t                         ent_mask [ENTRIES];

    // Control wires.
    logic [IDX_W-1:0] head_idx, tail_idx, hit_idx, tgt_idx;
    logic [CNT_W-1:0] occ;
    logic             full, empty, hit;
    logic             dn_fire, can_alloc, st_take, do_merge, do_alloc;
    line_t            st_line;
    wsel_t            st_word;
    ldata_t           base_data, new_data;
    lmask_t           base_mask, new_mask;

    // Split the store word address into line and word select.
    always_comb begin
        st_line = st_waddr[WADDR_W-1:WSEL_W];
        st_word = st_waddr[WSEL_W-1:0];
    end

    cwb_ring_ctrl #(.ENTRIES(ENTRIES)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_alloc),
        .pop      (dn_fire),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .occ      (occ),
        .full     (full),
        .empty    (empty)
    );

    cwb_line_match #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_match (
        .live     (ent_live),
        .lines    (ent_line),
        .query    (st_line),
        .skip_en  (dn_fire),
        .skip_idx (head_idx),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    // Downstream presentation of the oldest slot.
    always_comb begin
        dn_valid = !empty;
        dn_line  = ent_line[head_idx];
        dn_data  = ent_data[head_idx];
        dn_mask  = ent_mask[head_idx];
        dn_fire  = dn_valid && dn_ready;
    end

    // Store acceptance, stall and slot choice.
    always_comb begin
        can_alloc = !full || dn_fire;
        st_stall  = st_valid && !hit && !can_alloc;
        st_take   = st_valid && !st_stall;
        do_merge  = st_take && hit;
        do_alloc  = st_take && !hit;
        tgt_idx   = hit ? hit_idx : tail_idx;
        base_data = hit ? ent_data[hit_idx] : '0;
        base_mask = hit ? ent_mask[hit_idx] : '0;
    end

    cwb_byte_merge u_merge (
        .base_data (base_data),
        .base_mask (base_mask),
        .word_sel  (st_word),
        .wdata     (st_data),
        .be        (st_be),
        .out_data  (new_data),
        .out_mask  (new_mask)
    );

    // Slot live bits: cleared on drain, set on allocation (same slot may do both).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_live <= '0;
        end else begin
            if (dn_fire)  ent_live[head_idx] <= 1'b0;
            if (do_alloc) ent_live[tail_idx] <= 1'b1;
        end
    end

    // Slot payload update on merge or allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_line[i] <= '0;
                ent_data[i] <= '0;
                ent_mask[i] <= '0;
            end
        end else if (do_merge || do_alloc) begin
            ent_line[tgt_idx] <= st_line;
            ent_data[tgt_idx] <= new_data;
            ent_mask[tgt_idx] <= new_mask;
        end
    end
endmodule

// File: rtl/cwb_checker.sv
// Property checker for the coalescing write buffer, bound to cwb_top.
// Observes the port handshakes and the slot occupancy.
module cwb_checker
    import cwb_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  st_stall,
    input logic                  dn_valid,
    input logic                  dn_ready,
    input logic [LINE_W-1:0]     dn_line,
    input logic [LINE_BYTES-1:0] dn_mask,
    input logic [CNT_W-1:0]      occ
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(ENTRIES)); // R1
    AST_STALL_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> st_valid); // R4
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (occ == CNT_W'(ENTRIES)) && !dn_ready); // R4
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !dn_valid); // R5
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid); // R6
    AST_HEAD_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> $stable(dn_line)); // R6
    AST_MASK_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> ((dn_mask & $past(dn_mask)) == $past(dn_mask))); // R3
    AST_FULL_DRAIN_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ready |-> !st_stall); // R8
endmodule

bind cwb_top cwb_checker #(.ENTRIES(ENTRIES)) u_cwb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_stall (st_stall),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_line  (dn_line),
    .dn_mask  (dn_mask),
    .occ      (occ)
);

// File: tb/test_cwb_top.sv
// Bench for cwb_top: a slot-level reference model decides every cycle's
// expected stall and head slot; directed cases then an exhaustive sweep.
module test_cwb_top;
    import cwb_pkg::*;

    localparam int N = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  st_valid = 1'b0;
    logic [WADDR_W-1:0]    st_waddr = '0;
    logic [WDATA_W-1:0]    st_data = '0;
    logic [WORD_BYTES-1:0] st_be = '0;
    logic                  st_stall;
    logic                  dn_valid;
    logic                  dn_ready = 1'b0;
    logic [LINE_W-1:0]     dn_line;
    logic [DATA_W-1:0]     dn_data;
    logic [LINE_BYTES-1:0] dn_mask;

    cwb_top #(.ENTRIES(N)) i_cwb_top (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_waddr(st_waddr),
        .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_line(dn_line),
        .dn_data(dn_data), .dn_mask(dn_mask)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model: index 0 is the oldest slot.
    logic [LINE_W-1:0]     m_line [N];
    logic [DATA_W-1:0]     m_data [N];
    logic [LINE_BYTES-1:0] m_mask [N];
    int                    m_cnt = 0;

    task automatic check(input string tag, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Apply one store word to a model line image.
    task automatic model_write(input int k, input logic [2:0] w,
                               input logic [31:0] d, input logic [3:0] be);
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                m_data[k][(w*4+b)*8 +: 8] = d[b*8 +: 8];
                m_mask[k][w*4+b] = 1'b1;
            end
        end
    endtask

    // One cycle: drive, check against the model, then advance the model.
    task automatic step(input string tag, input bit v, input logic [LINE_W-1:0] ln,
                        input logic [2:0] w, input logic [31:0] d,
                        input logic [3:0] be, input bit rdy);
        bit fire, hit, exp_stall;
        int hi;
        @(negedge clk);
        st_valid = v; st_waddr = {ln, w}; st_data = d; st_be = be; dn_ready = rdy;
        #1;
        fire = (m_cnt > 0) && rdy;
        hit = 1'b0; hi = 0;
        for (int i = 0; i < m_cnt; i++) begin
            if (!(fire && i == 0) && m_line[i] == ln && !hit) begin hit = 1'b1; hi = i; end
        end
        exp_stall = v && !hit && (m_cnt == N) && !fire;
        check(tag, "st_stall", DATA_W'(st_stall), DATA_W'(exp_stall));
        check("R5", "dn_valid", DATA_W'(dn_valid), DATA_W'(m_cnt > 0));
        if (m_cnt > 0) begin
            check("R5", "dn_line", DATA_W'(dn_line), DATA_W'(m_line[0]));
            check("R2", "dn_data", dn_data, m_data[0]);
            check("R2", "dn_mask", DATA_W'(dn_mask), DATA_W'(m_mask[0]));
        end
        @(posedge clk);
        if (v && !exp_stall && hit) model_write(hi, w, d, be);
        if (fire) begin
            for (int i = 0; i < N - 1; i++) begin
                m_line[i] = m_line[i+1]; m_data[i] = m_data[i+1]; m_mask[i] = m_mask[i+1];
            end
            m_cnt--;
        end
        if (v && !exp_stall && !hit) begin
            m_line[m_cnt] = ln; m_data[m_cnt] = '0; m_mask[m_cnt] = '0;
            model_write(m_cnt, w, d, be);
            m_cnt++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state, idle cycle.
        step("R9", 0, '0, 3'd0, 32'h0, 4'h0, 1'b0);
        // R2 / R1: fill every slot with distinct lines while downstream waits.
        for (int i = 0; i < N; i++)
            step("R2", 1, LINE_W'(16 + i), 3'(i), 32'h1111_0000 + i, 4'hF, 1'b0);
        // R4: a fifth distinct line stalls while full with no drain.
        step("R4", 1, LINE_W'(40), 3'd1, 32'hDEAD_BEEF, 4'h3, 1'b0);
        step("R4", 1, LINE_W'(40), 3'd1, 32'hDEAD_BEEF, 4'h3, 1'b0);
        // R3: merges into a held line while full do not stall.
        step("R3", 1, LINE_W'(18), 3'd5, 32'hA5A5_5A5A, 4'h9, 1'b0);
        step("R3", 1, LINE_W'(18), 3'd2, 32'h0BAD_F00D, 4'h6, 1'b0);
        // R8: full buffer, drain and new line in the same cycle.
        step("R8", 1, LINE_W'(40), 3'd7, 32'hCAFE_0001, 4'hF, 1'b1);
        // R7: store to the line leaving this cycle opens a fresh slot.
        step("R7", 1, LINE_W'(17), 3'd3, 32'h7777_1234, 4'hC, 1'b1);
        step("R7", 0, '0, 3'd0, 32'h0, 4'h0, 1'b0);
        // R6: downstream holds off; head stays presented.
        for (int i = 0; i < 3; i++) step("R6", 0, '0, 3'd0, 32'h0, 4'h0, 1'b0);
        // R5: drain all, in order, to empty.
        for (int i = 0; i < 8; i++) step("R5", 0, '0, 3'd0, 32'h0, 4'h0, 1'b1);
        // Sweep: every line x word x enable over six lines, ready from an LFSR.
        for (int ln = 0; ln < 6; ln++)
            for (int w = 0; w < 8; w++)
                for (int be = 1; be < 16; be++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    step(lfsr[3] ? "R3" : "R4", 1, LINE_W'((ln * 5 + w + be) % 6),
                         3'(w), {lfsr, 8'(be), 8'(ln)}, 4'(be), lfsr[0] & lfsr[5]);
                end
        // R5: final drain delivers everything and leaves the buffer empty.
        for (int i = 0; i < 12; i++) step("R5", 0, '0, 3'd0, 32'h0, 4'h0, 1'b1);
        check("R5", "model empty", DATA_W'(m_cnt), '0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule